// File: doc/BRIEF.md
# Binary Hypercube Dimension-Order Router

This unit makes the routing decisions for one packet at a time as it crosses a binary n-cube of 2^DIM nodes. A header carrying a source and a destination node address comes in on a valid/ready injection stream. The unit XORs the two addresses into a correction vector with one bit per cube dimension. It counts the ones in that vector, which gives the number of hops the packet will take, and publishes that count.

The unit then offers one dimension at a time on a valid/ready hop stream. It always offers the lowest-numbered dimension still set in the vector. When the consumer accepts an offer, that bit is cleared. Once the vector is zero, the packet has reached its destination and the unit raises the eject flag. Acknowledging the eject frees the unit for the next header.

Back-pressure works on every stream:
- A header waits on `inj_valid` until `inj_ready` is high. While a packet is held, `inj_ready` stays low and any injection is ignored.
- An offered dimension stays on `hop_dim`/`hop_mask` unchanged until `hop_ready` takes it.
- The eject flag stays up until `ej_ready` acknowledges it.

Top module: `ecube_router`

## Requirements
- R1: After reset, `inj_ready` is 1, `hop_valid` and `ej_valid` are 0, and `hop_total` and `hop_left` are 0.
- R2: A header is accepted on a clock edge where `inj_valid` and `inj_ready` are both 1. From the next cycle until the eject handshake, `inj_ready` is 0.
- R3: From the cycle after acceptance, `hop_total` equals the number of bit positions in which source and destination differ. It holds that value until the next header is accepted.
- R4: While the correction vector is nonzero, `hop_valid` is 1. `hop_dim` is then the index of the lowest set bit of the vector, and `hop_mask` has only bit `hop_dim` set (bit i stands for dimension i).
- R5: On an edge where `hop_valid` and `hop_ready` are both 1, the offered bit is cleared, so the next offer is the next higher differing dimension. While `hop_ready` is 0, the offer stays unchanged.
- R6: The dimensions offered for one packet are exactly those in which source and destination differ, each offered once, in ascending order. Their count equals `hop_total`.
- R7: `ej_valid` is 1 exactly when a packet is held and its vector is zero, and `hop_valid` is then 0. A header whose source equals its destination gives `ej_valid` in the cycle after acceptance, with `hop_total` 0 and no dimension offered.
- R8: An edge where `ej_valid` and `ej_ready` are both 1 releases the packet: in the next cycle `ej_valid` is 0 and `inj_ready` is 1.
- R9: `hop_left` is the number of ones still set in the correction vector. It drops by one after each accepted hop.
- R10: Injection attempts made while a packet is held have no effect on the offered dimensions, `hop_total` or `hop_left`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inj_valid | input | 1 | Header offered |
| inj_ready | output | 1 | Unit free to take a header |
| inj_src | input | DIM | Source node address |
| inj_dst | input | DIM | Destination node address |
| hop_valid | output | 1 | A dimension to cross is offered |
| hop_ready | input | 1 | Consumer takes the offered dimension |
| hop_dim | output | max(1,clog2(DIM)) | Index of offered dimension |
| hop_mask | output | DIM | One-hot form of offered dimension |
| hop_total | output | clog2(DIM+1) | Path length of current packet |
| hop_left | output | clog2(DIM+1) | Hops still to take |
| ej_valid | output | 1 | Packet has arrived, eject |
| ej_ready | input | 1 | Eject acknowledged |

## Verification
Routing is tried with several address pairs:
- Source equal to destination, which isolates the zero-vector eject path.
- A single differing bit, which checks the length-one route.
- All bits differing, which exercises every dimension in order and the largest hop count.
- Alternating patterns such as 1010 against 0101 or 0000, which show whether the priority order skips cleared and never-set bits correctly.

Withheld `hop_ready` tells a held offer apart from one that advances on its own. Injection attempts made mid-route separate a unit that guards its header from one that overwrites it. Back-to-back packets show that the path length and vector are reloaded and not left over from the previous packet.

// File: rtl/ecube_pkg.sv
package ecube_pkg;
  typedef enum logic {
    ST_FREE = 1'b0,
    ST_HOLD = 1'b1
  } hold_state_t;

  function automatic int unsigned idx_width(input int unsigned dims);
    return (dims > 1) ? $clog2(dims) : 1;
  endfunction
endpackage

// File: rtl/ecube_lowbit.sv
module ecube_lowbit #(
  parameter int DIM = 4,
  parameter int IW  = 2
) (
  input  logic [DIM-1:0] vec_i,
  output logic [DIM-1:0] mask_o,
  output logic [IW-1:0]  idx_o,
  output logic           any_o
);
  // below[i] is high when some bit under position i is set
  logic [DIM:0] below;
  assign below[0] = 1'b0;

  for (genvar g = 0; g < DIM; g++) begin : g_chain
    assign below[g+1] = below[g] | vec_i[g];
    assign mask_o[g]  = vec_i[g] & ~below[g];
  end

  assign any_o = below[DIM];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < DIM; i++) begin
      if (mask_o[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/ecube_popcnt.sv
module ecube_popcnt #(
  parameter int DIM = 4,
  parameter int CW  = 3
) (
  input  logic [DIM-1:0] vec_i,
  output logic [CW-1:0]  cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < DIM; i++) begin
      cnt_o = cnt_o + CW'(vec_i[i]);
    end
  end
endmodule

// File: rtl/ecube_hdr_ctl.sv
module ecube_hdr_ctl
  import ecube_pkg::*;
#(
  parameter int DIM = 4,
  parameter int CW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic [DIM-1:0] load_vec_i,
  input  logic [CW-1:0]  load_cnt_i,
  input  logic           step_i,
  input  logic [DIM-1:0] step_mask_i,
  input  logic           release_i,
  output logic           held_o,
  output logic [DIM-1:0] vec_o,
  output logic [CW-1:0]  total_o,
  output logic [CW-1:0]  taken_o
);
  hold_state_t st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_FREE;
      vec_o   <= '0;
      total_o <= '0;
      taken_o <= '0;
    end else begin
      if (load_i) begin
        st_q    <= ST_HOLD;
        vec_o   <= load_vec_i;
        total_o <= load_cnt_i;
        taken_o <= '0;
      end else begin
        if (step_i) begin
          vec_o   <= vec_o & ~step_mask_i;
          taken_o <= taken_o + 1'b1;
        end
        if (release_i) st_q <= ST_FREE;
      end
    end
  end

  assign held_o = (st_q == ST_HOLD);

  // R5: a step only ever clears a bit that is currently set
  a_r5_step_hits_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> ((vec_o & step_mask_i) == step_mask_i));

  // R2: a load is never taken while a packet is held
  a_r2_no_load_when_held: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !held_o);
endmodule

// File: rtl/ecube_router.sv
module ecube_router
  import ecube_pkg::*;
#(
  parameter int DIM = 4
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    inj_valid,
  output logic                                    inj_ready,
  input  logic [DIM-1:0]                          inj_src,
  input  logic [DIM-1:0]                          inj_dst,
  output logic                                    hop_valid,
  input  logic                                    hop_ready,
  output logic [((DIM > 1) ? $clog2(DIM) : 1)-1:0] hop_dim,
  output logic [DIM-1:0]                          hop_mask,
  output logic [$clog2(DIM+1)-1:0]                hop_total,
  output logic [$clog2(DIM+1)-1:0]                hop_left,
  output logic                                    ej_valid,
  input  logic                                    ej_ready
);
  localparam int NODES = 1 << DIM;
  localparam int IW    = idx_width(DIM);
  localparam int CW    = $clog2(DIM+1);

  logic [DIM-1:0] diff_vec;
  logic [CW-1:0]  diff_cnt;
  logic [DIM-1:0] cur_vec;
  logic [CW-1:0]  taken;
  logic           held;
  logic           any_left;
  logic           inj_fire, hop_fire, ej_fire;

  assign diff_vec = inj_src ^ inj_dst;

  ecube_popcnt #(.DIM(DIM), .CW(CW)) i_cnt_new (
    .vec_i (diff_vec),
    .cnt_o (diff_cnt)
  );

  ecube_popcnt #(.DIM(DIM), .CW(CW)) i_cnt_left (
    .vec_i (cur_vec),
    .cnt_o (hop_left)
  );

  ecube_lowbit #(.DIM(DIM), .IW(IW)) i_pick (
    .vec_i  (cur_vec),
    .mask_o (hop_mask),
    .idx_o  (hop_dim),
    .any_o  (any_left)
  );

  assign inj_ready = ~held;
  assign hop_valid = held & any_left;
  assign ej_valid  = held & ~any_left;
  assign inj_fire  = inj_valid & inj_ready;
  assign hop_fire  = hop_valid & hop_ready;
  assign ej_fire   = ej_valid & ej_ready;

  ecube_hdr_ctl #(.DIM(DIM), .CW(CW)) i_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (inj_fire),
    .load_vec_i  (diff_vec),
    .load_cnt_i  (diff_cnt),
    .step_i      (hop_fire),
    .step_mask_i (hop_mask),
    .release_i   (ej_fire),
    .held_o      (held),
    .vec_o       (cur_vec),
    .total_o     (hop_total),
    .taken_o     (taken)
  );

  // R3: the published path length matches the loaded vector
  a_r3_total_matches: assert property (@(posedge clk) disable iff (!rst_n)
    inj_fire |=> (hop_total == hop_left));

  // R4: an offered dimension is one-hot and matches its index
  a_r4_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    hop_valid |-> ($countones(hop_mask) == 1 && hop_mask[hop_dim]));

  // R5: an offer not taken holds steady
  a_r5_offer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (hop_valid && !hop_ready) |=> (hop_valid && $stable(hop_dim)));

  // R9: each accepted hop lowers the remaining count by one
  a_r9_left_drops: assert property (@(posedge clk) disable iff (!rst_n)
    hop_fire |=> (hop_left == $past(hop_left) - 1'b1));

  // R6: at eject the hops taken equal the path length
  a_r6_eject_count: assert property (@(posedge clk) disable iff (!rst_n)
    ej_valid |-> (taken == hop_total));

  // R7: eject and hop offer never overlap
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ej_valid && hop_valid));

  // R7: equal addresses eject at once
  a_r7_self_eject: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_fire && inj_src == inj_dst) |=> (ej_valid && hop_total == '0));

  // R8: eject handshake frees the unit
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    ej_fire |=> (inj_ready && !ej_valid));

  initial begin
    a_nodes_ok: assert (NODES >= 2);
  end
endmodule

// File: tb/test_ecube_router.sv
module test_ecube_router;
  localparam int CLK_PERIOD = 10;
  localparam int DIM = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       inj_valid, hop_ready, ej_ready;
  logic [3:0] inj_src, inj_dst;
  logic       inj_ready, hop_valid, ej_valid;
  logic [1:0] hop_dim;
  logic [3:0] hop_mask;
  logic [2:0] hop_total, hop_left;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecube_router #(.DIM(DIM)) i_ecube_router (
    .clk(clk), .rst_n(rst_n),
    .inj_valid(inj_valid), .inj_ready(inj_ready),
    .inj_src(inj_src), .inj_dst(inj_dst),
    .hop_valid(hop_valid), .hop_ready(hop_ready),
    .hop_dim(hop_dim), .hop_mask(hop_mask),
    .hop_total(hop_total), .hop_left(hop_left),
    .ej_valid(ej_valid), .ej_ready(ej_ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic int ones(input logic [3:0] v);
    int c = 0;
    for (int i = 0; i < 4; i++) c += v[i];
    return c;
  endfunction

  // Full route of one packet; stall adds a withheld cycle before each hop,
  // noise drives foreign injections while the packet is held.
  task automatic route(input logic [3:0] s, input logic [3:0] d,
                       input bit stall, input bit noise);
    logic [3:0] diff = s ^ d;
    int left = ones(diff);
    chk("R2 ready before inject", inj_ready, 1);
    inj_valid = 1'b1; inj_src = s; inj_dst = d;
    step();
    inj_valid = noise; inj_src = ~s; inj_dst = s;
    chk("R2 ready low while held", inj_ready, 0);
    chk("R3 hop_total", hop_total, ones(diff));
    chk("R9 hop_left at start", hop_left, left);
    for (int i = 0; i < 4; i++) begin
      if (diff[i]) begin
        if (stall) begin
          hop_ready = 1'b0;
          step();
          chk("R5 hold without ready", hop_dim, i);
          chk("R5 valid held", hop_valid, 1);
        end
        chk("R4 hop_valid", hop_valid, 1);
        chk("R6 hop_dim order", hop_dim, i);
        chk("R4 hop_mask", hop_mask, 1 << i);
        chk("R10 total unaffected", hop_total, ones(diff));
        chk("R7 no eject mid-route", ej_valid, 0);
        hop_ready = 1'b1;
        step();
        hop_ready = 1'b0;
        left--;
        chk("R9 hop_left drops", hop_left, left);
      end
    end
    inj_valid = 1'b0;
    chk("R7 eject raised", ej_valid, 1);
    chk("R7 no hop at eject", hop_valid, 0);
    chk("R6 all hops used", hop_left, 0);
    step();
    chk("R7 eject held without ready", ej_valid, 1);
    ej_ready = 1'b1;
    step();
    ej_ready = 1'b0;
    chk("R8 eject cleared", ej_valid, 0);
    chk("R8 ready again", inj_ready, 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; inj_valid = 0; hop_ready = 0; ej_ready = 0;
    inj_src = '0; inj_dst = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R1 inj_ready", inj_ready, 1);
    chk("R1 hop_valid", hop_valid, 0);
    chk("R1 ej_valid", ej_valid, 0);
    chk("R1 hop_total", hop_total, 0);
    chk("R1 hop_left", hop_left, 0);
  endtask

  task automatic t_self();
    chk("R2 ready before inject", inj_ready, 1);
    inj_valid = 1'b1; inj_src = 4'h5; inj_dst = 4'h5;
    step();
    inj_valid = 1'b0;
    chk("R7 self eject", ej_valid, 1);
    chk("R7 zero total", hop_total, 0);
    chk("R7 no hop", hop_valid, 0);
    ej_ready = 1'b1;
    step();
    ej_ready = 1'b0;
    chk("R8 ready after self", inj_ready, 1);
  endtask

  initial begin
    t_reset();
    t_self();
    route(4'h3, 4'h7, 1'b0, 1'b0);  // single dimension
    route(4'h0, 4'hF, 1'b0, 1'b0);  // every dimension
    route(4'hA, 4'h5, 1'b1, 1'b0);  // all differ, with stalls
    route(4'hA, 4'h0, 1'b0, 1'b0);  // skips unset bits
    route(4'h9, 4'hC, 1'b0, 1'b1);  // injections while held
    route(4'h1, 4'hE, 1'b1, 1'b1);  // stalls and noise together
    route(4'h6, 4'h6 ^ 4'h8, 1'b0, 1'b0); // top dimension only
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule